// File: doc/BRIEF.md
# Interrupt and Status Register Unit

This block keeps the interrupt, status, sequence-step, flags and first configuration registers of a bus-attached storage controller, and drives one level-sensitive interrupt line. Other logic in the controller asks for an interrupt with a one-cycle `raise_req` pulse, reports a terminal count with `tc_set`, and loads the flags byte with `flags_ld`. Software reads and writes the registers over a byte-wide port. Reading the interrupt register is destructive: it returns the current value and, at the same clock edge, clears the pending condition.

A write to the command address carries the simple control commands. Their effects on the registers are applied here, and so is their effect on the interrupt line. The interrupt line comes from a two-state machine. `ST_IDLE` means nothing is pending and `ST_PEND` means an interrupt is pending. The machine has these transitions:

- `IDLE->PEND` on any raise request (from `raise_req` or from a command).
- `PEND->IDLE` on an interrupt-register read that has no raise in the same cycle.
- `ANY->IDLE` on the chip-reset command or on `rst_n`.

Raise requests that arrive while the machine is in `ST_PEND` leave it where it is. The status byte shows the pending state in bit 7 and the terminal-count bit in bit 4. Every other status bit reads as 0.

Register addresses:

| Address | Register |
|---|---|
| 3 | command (write only) |
| 4 | status |
| 5 | interrupt |
| 6 | sequence step |
| 7 | flags |
| 8 | configuration 1 |

Command codes, decoded on all 8 bits:

| Code | Command |
|---|---|
| 0x00 | no-op |
| 0x01 | flush |
| 0x02 | chip reset |
| 0x03 | bus reset |
| 0x08 | message accepted |
| 0x0C | enable selection |
| 0x0D | disable selection |

Top module: `isr_unit`

## Requirements
- R1: After `rst_n` is asserted, `irq_o` is 0. Status, interrupt, sequence step and flags each read 0x00, and configuration 1 reads 0x07.
- R2: A `raise_req` pulse sets status bit 7 and drives `irq_o` high from the next cycle. Further raises while an interrupt is pending change nothing.
- R3: A read of address 5 returns the value held before the read in the same cycle. From the next cycle the interrupt register is 0x00, status bit 4 is clear, the sequence step is 4, and the interrupt is lowered.
- R4: When a read of address 5 and a raise request fall in the same cycle, the raise wins: `irq_o` stays 1, while the interrupt register and sequence step are still cleared and set as in R3.
- R5: The bus-reset command (0x03) makes the interrupt register 0x80. It raises the interrupt only when bit 6 of configuration 1 is 0.
- R6: The flush command (0x01) makes the interrupt register 0x08 and zeroes the sequence step and flags, without raising the interrupt.
- R7: The chip-reset command (0x02) lowers `irq_o` and zeroes status, interrupt, sequence step and flags. It sets configuration 1 to 0x07 and ignores `raise_req`, `tc_set` and `flags_ld` in the same cycle.
- R8: The enable-selection command (0x0C) zeroes the interrupt register and leaves `irq_o` unchanged. The disable-selection command (0x0D) zeroes it and raises the interrupt.
- R9: The message-accepted command (0x08) makes the interrupt register 0x20, zeroes the sequence step and flags, and raises the interrupt.
- R10: Configuration 1 reads back the byte last written to address 8. `tc_set` sets status bit 4. `flags_ld` loads `flags_val` into the flags register, and that load takes precedence over a same-cycle flush.
- R11: A no-op (0x00), or any code not listed, leaves every register and `irq_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as chip reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on address 5) |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data, combinational from the current register state |
| raise_req | input | 1 | Interrupt request from controller logic |
| tc_set | input | 1 | Sets the terminal-count status bit |
| flags_ld | input | 1 | Load strobe for the flags register |
| flags_val | input | DATA_W (8) | Value for the flags register |
| irq_o | output | 1 | Level interrupt line |

## Verification
Read data is combinational, so a read's return value is due in the same cycle as the strobe. Every register effect of a strobe, command or raise is due on the next cycle, after exactly one clock edge. Inputs are driven on the falling edge. Read data is sampled 1 time unit after the strobe is applied, so it always shows the state from before the edge. The reference model advances on each rising edge, and `irq_o` is compared with it on every falling edge. Follow-up reads look at the register effects one cycle after the edge that applied them.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int A_CMD   = 3;
    localparam int A_STAT  = 4;
    localparam int A_INTR  = 5;
    localparam int A_SEQ   = 6;
    localparam int A_FLAGS = 7;
    localparam int A_CFG1  = 8;

    localparam logic [7:0] C_NOP    = 8'h00;
    localparam logic [7:0] C_FLUSH  = 8'h01;
    localparam logic [7:0] C_CHIP   = 8'h02;
    localparam logic [7:0] C_BUSRST = 8'h03;
    localparam logic [7:0] C_MSGACC = 8'h08;
    localparam logic [7:0] C_ENSEL  = 8'h0C;
    localparam logic [7:0] C_DISSEL = 8'h0D;

    localparam int PEND_BIT    = 7;
    localparam int TC_BIT      = 4;
    localparam int RPT_OFF_BIT = 6;

    typedef struct packed {
        logic flush;
        logic chip;
        logic busrst;
        logic msgacc;
        logic ensel;
        logic dissel;
    } cmd_t;

    typedef enum logic {ST_IDLE, ST_PEND} irq_state_e;
endpackage

// File: rtl/isr_cmd_decode.sv
module isr_cmd_decode
    import isr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              report_off,
    output cmd_t              cmd,
    output logic              cmd_raise
);
    logic hit;

    always_comb begin
        hit = reg_wr && (reg_addr == ADDR_W'(A_CMD));
        cmd = '0;
        if (hit) begin
            case (reg_wdata)
                DATA_W'(C_FLUSH):  cmd.flush  = 1'b1;
                DATA_W'(C_CHIP):   cmd.chip   = 1'b1;
                DATA_W'(C_BUSRST): cmd.busrst = 1'b1;
                DATA_W'(C_MSGACC): cmd.msgacc = 1'b1;
                DATA_W'(C_ENSEL):  cmd.ensel  = 1'b1;
                DATA_W'(C_DISSEL): cmd.dissel = 1'b1;
                default: ;
            endcase
        end
        cmd_raise = (cmd.busrst && !report_off) || cmd.msgacc || cmd.dissel;
    end
endmodule

// File: rtl/isr_irq_fsm.sv
module isr_irq_fsm
    import isr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chip,
    input  logic set,
    input  logic clr,
    output logic irq_o
);
    irq_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (set) state_nxt = ST_PEND;
            ST_PEND: if (clr && !set) state_nxt = ST_IDLE;
        endcase
        if (chip) state_nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        irq_o = (state == ST_PEND);
    end
endmodule

// File: rtl/isr_regs.sv
module isr_regs
    import isr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SEQ_W    = 3,
    parameter int SEQ_DONE = 4,
    parameter int CFG1_RST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic              intr_rd,
    input  logic              cfg1_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tc_set,
    input  logic              flags_ld,
    input  logic [DATA_W-1:0] flags_val,
    output logic [DATA_W-1:0] intr_q,
    output logic [SEQ_W-1:0]  seq_q,
    output logic [DATA_W-1:0] flags_q,
    output logic [DATA_W-1:0] cfg1_q,
    output logic              tc_q
);
    localparam logic [DATA_W-1:0] FLAG_RST = DATA_W'(8'h80);
    localparam logic [DATA_W-1:0] FLAG_DC  = DATA_W'(8'h20);
    localparam logic [DATA_W-1:0] FLAG_FC  = DATA_W'(8'h08);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intr_q  <= '0;
            seq_q   <= '0;
            flags_q <= '0;
            cfg1_q  <= DATA_W'(CFG1_RST);
            tc_q    <= 1'b0;
        end else if (cmd.chip) begin
            intr_q  <= '0;
            seq_q   <= '0;
            flags_q <= '0;
            cfg1_q  <= DATA_W'(CFG1_RST);
            tc_q    <= 1'b0;
        end else begin
            if (intr_rd) begin
                intr_q <= '0;
                tc_q   <= 1'b0;
                seq_q  <= SEQ_W'(SEQ_DONE);
            end
            if (cmd.flush) begin
                intr_q  <= FLAG_FC;
                seq_q   <= '0;
                flags_q <= '0;
            end
            if (cmd.busrst) intr_q <= FLAG_RST;
            if (cmd.msgacc) begin
                intr_q  <= FLAG_DC;
                seq_q   <= '0;
                flags_q <= '0;
            end
            if (cmd.ensel || cmd.dissel) intr_q <= '0;
            if (cfg1_wr)  cfg1_q  <= wdata;
            if (tc_set)   tc_q    <= 1'b1;
            if (flags_ld) flags_q <= flags_val;
        end
    end
endmodule

// File: rtl/isr_unit.sv
module isr_unit
    import isr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int SEQ_W    = 3,
    parameter int SEQ_DONE = 4,
    parameter int CFG1_RST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              raise_req,
    input  logic              tc_set,
    input  logic              flags_ld,
    input  logic [DATA_W-1:0] flags_val,
    output logic              irq_o
);
    cmd_t              cmd;
    logic              cmd_raise;
    logic              intr_rd;
    logic              cfg1_wr;
    logic [DATA_W-1:0] intr_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [DATA_W-1:0] flags_q;
    logic [DATA_W-1:0] cfg1_q;
    logic              tc_q;
    logic [DATA_W-1:0] stat_byte;

    assign intr_rd = reg_rd && (reg_addr == ADDR_W'(A_INTR));
    assign cfg1_wr = reg_wr && (reg_addr == ADDR_W'(A_CFG1));

    isr_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .report_off(cfg1_q[RPT_OFF_BIT]),
        .cmd       (cmd),
        .cmd_raise (cmd_raise)
    );

    isr_irq_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .chip (cmd.chip),
        .set  (raise_req || cmd_raise),
        .clr  (intr_rd),
        .irq_o(irq_o)
    );

    isr_regs #(
        .DATA_W(DATA_W), .SEQ_W(SEQ_W), .SEQ_DONE(SEQ_DONE), .CFG1_RST(CFG1_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .intr_rd  (intr_rd),
        .cfg1_wr  (cfg1_wr),
        .wdata    (reg_wdata),
        .tc_set   (tc_set),
        .flags_ld (flags_ld),
        .flags_val(flags_val),
        .intr_q   (intr_q),
        .seq_q    (seq_q),
        .flags_q  (flags_q),
        .cfg1_q   (cfg1_q),
        .tc_q     (tc_q)
    );

    always_comb begin
        stat_byte           = '0;
        stat_byte[PEND_BIT] = irq_o;
        stat_byte[TC_BIT]   = tc_q;
        case (reg_addr)
            ADDR_W'(A_STAT):  reg_rdata = stat_byte;
            ADDR_W'(A_INTR):  reg_rdata = intr_q;
            ADDR_W'(A_SEQ):   reg_rdata = DATA_W'(seq_q);
            ADDR_W'(A_FLAGS): reg_rdata = flags_q;
            ADDR_W'(A_CFG1):  reg_rdata = cfg1_q;
            default:          reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/isr_unit_chk.sv
module isr_unit_chk
    import isr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int SEQ_W    = 3,
    parameter int SEQ_DONE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              raise_req,
    input logic              irq_o,
    input logic [DATA_W-1:0] intr_q,
    input logic [SEQ_W-1:0]  seq_q,
    input logic [DATA_W-1:0] cfg1_q
);
    logic is_cmd, is_chip, is_busrst, is_dissel, is_intr_rd;
    assign is_cmd     = reg_wr && (reg_addr == ADDR_W'(A_CMD));
    assign is_chip    = is_cmd && (reg_wdata == DATA_W'(C_CHIP));
    assign is_busrst  = is_cmd && (reg_wdata == DATA_W'(C_BUSRST));
    assign is_dissel  = is_cmd && (reg_wdata == DATA_W'(C_DISSEL));
    assign is_intr_rd = reg_rd && (reg_addr == ADDR_W'(A_INTR));

    p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        raise_req && !is_chip |=> irq_o);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_intr_rd && !raise_req && !reg_wr |=> !irq_o && intr_q == '0 && seq_q == SEQ_W'(SEQ_DONE));

    p_raise_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_intr_rd && raise_req && !reg_wr |=> irq_o && intr_q == '0);

    p_busrst_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_busrst && cfg1_q[RPT_OFF_BIT] && !irq_o && !raise_req && !reg_rd |=> !irq_o && intr_q == DATA_W'(8'h80));

    p_chip_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_chip |=> !irq_o && intr_q == '0 && cfg1_q == DATA_W'(7));

    p_dissel_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_dissel |=> irq_o && intr_q == '0);
endmodule

bind isr_unit isr_unit_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W), .SEQ_DONE(SEQ_DONE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .raise_req(raise_req),
    .irq_o    (irq_o),
    .intr_q   (intr_q),
    .seq_q    (seq_q),
    .cfg1_q   (cfg1_q)
);

// File: tb/isr_unit_test.sv
module isr_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       raise_req = 1'b0, tc_set = 1'b0, flags_ld = 1'b0;
    logic [7:0] flags_val = '0;
    logic       irq_o;

    int checks = 0, fails = 0;
    bit running = 1'b0;

    int m_pend, m_intr, m_seq, m_flags, m_cfg1, m_tc;

    always #(CLK_PERIOD/2) clk = ~clk;

    isr_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .raise_req(raise_req), .tc_set(tc_set), .flags_ld(flags_ld),
        .flags_val(flags_val), .irq_o(irq_o)
    );

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit raise, chip;
        raise = 1'b0;
        chip  = 1'b0;
        if (!rst_n) begin
            m_pend = 0; m_intr = 0; m_seq = 0; m_flags = 0; m_cfg1 = 7; m_tc = 0;
        end else begin
            if (reg_rd && reg_addr == 5) begin
                m_intr = 0; m_tc = 0; m_seq = 4; m_pend = 0;
            end
            if (reg_wr && reg_addr == 3) begin
                case (reg_wdata)
                    8'h01: begin m_intr = 'h08; m_seq = 0; m_flags = 0; end
                    8'h02: chip = 1'b1;
                    8'h03: begin m_intr = 'h80; if ((m_cfg1 & 'h40) == 0) raise = 1'b1; end
                    8'h08: begin m_intr = 'h20; m_seq = 0; m_flags = 0; raise = 1'b1; end
                    8'h0C: m_intr = 0;
                    8'h0D: begin m_intr = 0; raise = 1'b1; end
                    default: ;
                endcase
            end
            if (reg_wr && reg_addr == 8) m_cfg1 = reg_wdata;
            if (chip) begin
                m_pend = 0; m_intr = 0; m_seq = 0; m_flags = 0; m_cfg1 = 7; m_tc = 0;
            end else begin
                if (tc_set) m_tc = 1;
                if (flags_ld) m_flags = flags_val;
                if (raise || raise_req) m_pend = 1;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compare the interrupt line with the model on every falling edge.
    always @(negedge clk) begin
        if (running && rst_n) check("R2 irq_o vs model", int'(irq_o), m_pend);
    end

    task automatic rd_chk(string tag, int a, int exp);
        reg_rd = 1'b1; reg_addr = 4'(a);
        #1;
        check(tag, int'(reg_rdata), exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_raise();
        raise_req = 1'b1; @(negedge clk); raise_req = 1'b0;
    endtask

    task automatic pulse_tc();
        tc_set = 1'b1; @(negedge clk); tc_set = 1'b0;
    endtask

    task automatic load_flags(int v);
        flags_ld = 1'b1; flags_val = 8'(v); @(negedge clk); flags_ld = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        // R1 reset state
        check("R1 irq_o", int'(irq_o), 0);
        rd_chk("R1 status", 4, 'h00);
        rd_chk("R1 seq", 6, 'h00);
        rd_chk("R1 flags", 7, 'h00);
        rd_chk("R1 cfg1", 8, 'h07);
        rd_chk("R1 intr", 5, 'h00);
        // R2 raise
        pulse_raise();
        check("R2 irq high", int'(irq_o), 1);
        rd_chk("R2 status pend", 4, 'h80);
        pulse_raise();
        rd_chk("R2 repeat raise", 4, 'h80);
        // R3 destructive read
        pulse_tc();
        rd_chk("R10 tc bit", 4, 'h90);
        wr(3, 'h03);
        rd_chk("R3 prior value", 5, 'h80);
        check("R3 irq lowered", int'(irq_o), 0);
        rd_chk("R3 tc cleared", 4, 'h00);
        rd_chk("R3 seq done", 6, 'h04);
        rd_chk("R3 intr zero", 5, 'h00);
        // R4 raise wins over read
        wr(3, 'h03);
        raise_req = 1'b1;
        rd_chk("R4 prior value", 5, 'h80);
        raise_req = 1'b0;
        check("R4 irq kept", int'(irq_o), 1);
        rd_chk("R4 intr zero", 5, 'h00);
        check("R4 cleared after", int'(irq_o), 0);
        // R5 bus reset masking
        wr(8, 'h47);
        rd_chk("R10 cfg1 readback", 8, 'h47);
        wr(3, 'h03);
        check("R5 masked no irq", int'(irq_o), 0);
        rd_chk("R5 intr flag masked", 5, 'h80);
        wr(8, 'h07);
        wr(3, 'h03);
        check("R5 unmasked irq", int'(irq_o), 1);
        rd_chk("R5 intr flag", 5, 'h80);
        // R6 flush
        load_flags('h5A);
        rd_chk("R10 flags load", 7, 'h5A);
        wr(3, 'h01);
        check("R6 no raise", int'(irq_o), 0);
        rd_chk("R6 seq zero", 6, 'h00);
        rd_chk("R6 flags zero", 7, 'h00);
        rd_chk("R6 intr fc", 5, 'h08);
        // R10 flags load beats flush in the same cycle
        flags_ld = 1'b1; flags_val = 8'h3C;
        wr(3, 'h01);
        flags_ld = 1'b0;
        rd_chk("R10 load over flush", 7, 'h3C);
        rd_chk("R6 intr fc again", 5, 'h08);
        // R9 message accepted
        load_flags('h33);
        wr(3, 'h08);
        check("R9 raise", int'(irq_o), 1);
        rd_chk("R9 seq zero", 6, 'h00);
        rd_chk("R9 flags zero", 7, 'h00);
        rd_chk("R9 intr dc", 5, 'h20);
        // R8 selection commands
        wr(8, 'h40);
        wr(3, 'h03);
        wr(3, 'h0C);
        check("R8 ensel no irq", int'(irq_o), 0);
        rd_chk("R8 ensel intr zero", 5, 'h00);
        wr(3, 'h0D);
        check("R8 dissel irq", int'(irq_o), 1);
        rd_chk("R8 dissel intr zero", 5, 'h00);
        // R11 no-op and unknown codes
        pulse_tc();
        load_flags('h11);
        wr(3, 'h00);
        wr(3, 'h85);
        check("R11 irq unchanged", int'(irq_o), 0);
        rd_chk("R11 status", 4, 'h10);
        rd_chk("R11 flags", 7, 'h11);
        rd_chk("R11 seq", 6, 'h04);
        rd_chk("R11 cfg1", 8, 'h40);
        // R7 chip reset
        pulse_raise();
        raise_req = 1'b1; tc_set = 1'b1; flags_ld = 1'b1; flags_val = 8'hEE;
        wr(3, 'h02);
        raise_req = 1'b0; tc_set = 1'b0; flags_ld = 1'b0;
        check("R7 irq low", int'(irq_o), 0);
        rd_chk("R7 status", 4, 'h00);
        rd_chk("R7 cfg1", 8, 'h07);
        rd_chk("R7 flags", 7, 'h00);
        rd_chk("R7 seq", 6, 'h00);
        rd_chk("R7 intr", 5, 'h00);
        // R1 reset input mid-run
        wr(8, 'h55);
        pulse_raise();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", int'(irq_o), 0);
        rd_chk("R1 cfg1 after reset", 8, 'h07);
        rd_chk("R1 status after reset", 4, 'h00);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule